// File: doc/BRIEF.md
# Bidirectional Link Mode Controller

This block decides, cycle by cycle, how one physical link between two neighbouring mesh routers is used. Each router side holds a count of packets that still need the link. A side raises its channel request while that count is non-zero. The controller looks at the pair of requests and picks one of three link modes:

- Balanced: each direction moves one flit per clock phase.
- Left-to-right burst: the left router drives both phases toward the right.
- Right-to-left burst: the mirror of the left-to-right burst.

When a burst ends, the controller spends one cycle in a drain state. During that cycle the bursting side stays out of switch allocation, so that its second-phase flit can clear the middle of the link before new traffic arrives. The other side keeps receiving during that cycle.

The controller models the half-cycle timing with single-edge registers. The requests are captured in a sample stage, which stands for the mid-cycle sampling point. The state and mode outputs then update one edge later, which gives a two-cycle decision latency. The datapath, flit storage and routing logic are not part of this block.

Top module: `bilink_mode_ctrl`

## Requirements
- R1: While the synchronous reset is high, the following hold: both counts are 0, both requests are 0, the mode is balanced and both drain flags are 0.
- R2: A side's count rises by 1 when its new-packet input is high and falls by 1 when its tail-done input is high. When both inputs are high in the same cycle, the count is left unchanged.
- R3: A count stays at its maximum value when it is incremented alone. A count stays at 0 when it is decremented alone.
- R4: A side's channel request is 1 exactly when its count is greater than 0.
- R5: From the balanced state, the request pair (left=1, right=0) enters left-to-right burst and the pair (0,1) enters right-to-left burst. The pairs (0,0) and (1,1) keep the balanced state.
- R6: A burst state continues only while the same single side requests. Any other pair moves the controller to the drain state that matches the burst direction.
- R7: A drain state lasts exactly one cycle. After it, the pair (1,0) enters left-to-right burst, the pair (0,1) enters right-to-left burst, and any other pair returns to the balanced state.
- R8: The left drain flag is 1 only in the drain that follows a left-to-right burst. The right drain flag is 1 only in the drain that follows a right-to-left burst. The two flags are never high together.
- R9: The mode output is one-hot. Bit 0 means balanced, and it is also shown during the drain states. Bit 1 means left-to-right burst. Bit 2 means right-to-left burst.
- R10: The request pair present on the request outputs after clock edge E sets the state that the mode and drain outputs show after edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_pkt_new | input | 1 | Left side: a packet entered route computation |
| l_tail_done | input | 1 | Left side: a tail flit finished switch allocation |
| r_pkt_new | input | 1 | Right side: a packet entered route computation |
| r_tail_done | input | 1 | Right side: a tail flit finished switch allocation |
| l_count | output | CNT_W | Left pending-packet count |
| r_count | output | CNT_W | Right pending-packet count |
| l_req | output | 1 | Left channel request |
| r_req | output | 1 | Right channel request |
| mode | output | 3 | One-hot link mode: bit0 balanced, bit1 left-to-right, bit2 right-to-left |
| l_drain | output | 1 | Left side excluded from switch allocation (drain state) |
| r_drain | output | 1 | Right side excluded from switch allocation (drain state) |

## Verification
A count change and its request are due one edge after the packet or tail pulse. A request pair drives the mode and drain outputs two edges after that, because it passes through the sample register and then the state register. The bench keeps a cycle-accurate model of these three stages. For every driven cycle it pushes one expected record, and the monitor compares that record shortly after the next rising edge. This means each output is checked in exactly the cycle it is due, with no tolerance window.

// File: rtl/bidir_link_pkg.sv
package bidir_link_pkg;
  typedef enum logic [2:0] {
    ST_BAL      = 3'd0,
    ST_BURST_LR = 3'd1,
    ST_BURST_RL = 3'd2,
    ST_DRAIN_LR = 3'd3,
    ST_DRAIN_RL = 3'd4
  } link_state_e;

  localparam int MODE_W   = 3;
  localparam int MODE_BAL = 0;
  localparam int MODE_LR  = 1;
  localparam int MODE_RL  = 2;
endpackage

// File: rtl/pkt_req_counter.sv
module pkt_req_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_new,
  input  logic             tail_done,
  output logic [CNT_W-1:0] count,
  output logic             req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (pkt_new && !tail_done) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (tail_done && !pkt_new) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
  assign req   = (cnt_q != '0);

  // R3
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && pkt_new && !tail_done) |=> cnt_q == CNT_MAX);
  // R3
  cnt_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && tail_done && !pkt_new) |=> cnt_q == '0);
  // R2
  cnt_both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_new && tail_done) |=> $stable(cnt_q));
endmodule

// File: rtl/req_sampler.sv
module req_sampler (
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic r_req,
  output logic l_req_s,
  output logic r_req_s
);
  always_ff @(posedge clk) begin
    if (rst) begin
      l_req_s <= 1'b0;
      r_req_s <= 1'b0;
    end else begin
      l_req_s <= l_req;
      r_req_s <= r_req;
    end
  end
endmodule

// File: rtl/link_mode_fsm.sv
module link_mode_fsm
  import bidir_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              l_req_s,
  input  logic              r_req_s,
  output logic [MODE_W-1:0] mode,
  output logic              l_drain,
  output logic              r_drain
);
  link_state_e state_q, state_d;
  logic only_l, only_r;

  assign only_l = l_req_s && !r_req_s;
  assign only_r = r_req_s && !l_req_s;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BURST_LR: state_d = only_l ? ST_BURST_LR : ST_DRAIN_LR;
      ST_BURST_RL: state_d = only_r ? ST_BURST_RL : ST_DRAIN_RL;
      default: begin
        if (only_l)      state_d = ST_BURST_LR;
        else if (only_r) state_d = ST_BURST_RL;
        else             state_d = ST_BAL;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_BAL;
      mode    <= MODE_W'(1) << MODE_BAL;
      l_drain <= 1'b0;
      r_drain <= 1'b0;
    end else begin
      state_q <= state_d;
      l_drain <= (state_d == ST_DRAIN_LR);
      r_drain <= (state_d == ST_DRAIN_RL);
      case (state_d)
        ST_BURST_LR: mode <= MODE_W'(1) << MODE_LR;
        ST_BURST_RL: mode <= MODE_W'(1) << MODE_RL;
        default:     mode <= MODE_W'(1) << MODE_BAL;
      endcase
    end
  end

  // R9
  mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(mode));
  // R8
  drain_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_drain && r_drain));
  // R7
  drain_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (l_drain || r_drain) |=> !(l_drain || r_drain));
  // R6
  lr_exit_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[MODE_LR] && !only_l) |=> (l_drain && mode[MODE_BAL]));
  // R6
  rl_exit_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[MODE_RL] && !only_r) |=> (r_drain && mode[MODE_BAL]));
  // R5
  bal_to_lr_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[MODE_BAL] && only_l) |=> mode[MODE_LR]);
endmodule

// File: rtl/bilink_mode_ctrl.sv
module bilink_mode_ctrl
  import bidir_link_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_pkt_new,
  input  logic              l_tail_done,
  input  logic              r_pkt_new,
  input  logic              r_tail_done,
  output logic [CNT_W-1:0]  l_count,
  output logic [CNT_W-1:0]  r_count,
  output logic              l_req,
  output logic              r_req,
  output logic [MODE_W-1:0] mode,
  output logic              l_drain,
  output logic              r_drain
);
  localparam int SIDES = 2;

  logic [SIDES-1:0]            pkt_new_v, tail_v, req_v;
  logic [SIDES-1:0][CNT_W-1:0] cnt_v;
  logic                        l_req_s, r_req_s;

  assign pkt_new_v = {r_pkt_new, l_pkt_new};
  assign tail_v    = {r_tail_done, l_tail_done};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    pkt_req_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .pkt_new   (pkt_new_v[s]),
      .tail_done (tail_v[s]),
      .count     (cnt_v[s]),
      .req       (req_v[s])
    );
  end

  assign l_count = cnt_v[0];
  assign r_count = cnt_v[1];
  assign l_req   = req_v[0];
  assign r_req   = req_v[1];

  req_sampler u_smp (
    .clk     (clk),
    .rst     (rst),
    .l_req   (l_req),
    .r_req   (r_req),
    .l_req_s (l_req_s),
    .r_req_s (r_req_s)
  );

  link_mode_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .l_req_s (l_req_s),
    .r_req_s (r_req_s),
    .mode    (mode),
    .l_drain (l_drain),
    .r_drain (r_drain)
  );

  // R4
  req_matches_count_chk: assert property (@(posedge clk) disable iff (rst)
    (l_req == (l_count != '0)) && (r_req == (r_count != '0)));
endmodule

// File: tb/tb_bilink_mode_ctrl.sv
`timescale 1ns/1ps
module tb_bilink_mode_ctrl;
  localparam int CW   = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_pkt_new = 0, l_tail_done = 0, r_pkt_new = 0, r_tail_done = 0;
  logic [CW-1:0] l_count, r_count;
  logic l_req, r_req, l_drain, r_drain;
  logic [2:0] mode;

  always #2.5 clk = ~clk;

  bilink_mode_ctrl #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst),
    .l_pkt_new(l_pkt_new), .l_tail_done(l_tail_done),
    .r_pkt_new(r_pkt_new), .r_tail_done(r_tail_done),
    .l_count(l_count), .r_count(r_count),
    .l_req(l_req), .r_req(r_req),
    .mode(mode), .l_drain(l_drain), .r_drain(r_drain)
  );

  typedef struct {
    bit rst; int lc; int rc; bit lq; bit rq; int md; bit ld; bit rd;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  // model: 0 bal, 1 burst LR, 2 burst RL, 3 drain LR, 4 drain RL
  int m_lc = 0, m_rc = 0, m_st = 0;
  bit m_ls = 0, m_rs = 0;

  function automatic int cnt_nxt(int c, bit inc, bit dec);
    if (inc && !dec) return (c == MAXC) ? c : c + 1;
    if (dec && !inc) return (c == 0) ? 0 : c - 1;
    return c;
  endfunction

  function automatic int st_nxt(int s, bit l, bit r);
    bit ol = l && !r;
    bit orr = r && !l;
    if (s == 1) return ol ? 1 : 3;
    if (s == 2) return orr ? 2 : 4;
    if (ol) return 1;
    if (orr) return 2;
    return 0;
  endfunction

  task automatic step(input bit r, input bit ln, input bit lt, input bit rn, input bit rt);
    exp_t e;
    int nlc, nrc, nst;
    @(negedge clk);
    rst = r; l_pkt_new = ln; l_tail_done = lt; r_pkt_new = rn; r_tail_done = rt;
    if (r) begin
      m_lc = 0; m_rc = 0; m_st = 0; m_ls = 0; m_rs = 0;
    end else begin
      nlc = cnt_nxt(m_lc, ln, lt);
      nrc = cnt_nxt(m_rc, rn, rt);
      nst = st_nxt(m_st, m_ls, m_rs);
      m_ls = (m_lc > 0);
      m_rs = (m_rc > 0);
      m_lc = nlc; m_rc = nrc; m_st = nst;
    end
    e.rst = r; e.lc = m_lc; e.rc = m_rc; e.lq = (m_lc > 0); e.rq = (m_rc > 0);
    e.md = (m_st == 1) ? 2 : (m_st == 2) ? 4 : 1;
    e.ld = (m_st == 3); e.rd = (m_st == 4);
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        if (e.rst) begin
          chk(l_count == 0 && r_count == 0 && mode == 3'b001 && !l_drain && !r_drain,
              "R1 reset state", {l_count, r_count, mode}, 1);
        end else begin
          chk(int'(l_count) == e.lc, "R2/R3 left count", l_count, e.lc);
          chk(int'(r_count) == e.rc, "R2/R3 right count", r_count, e.rc);
          chk(l_req == e.lq && r_req == e.rq, "R4 requests", {l_req, r_req}, {e.lq, e.rq});
          chk(int'(mode) == e.md, "R5 R6 R7 R9 R10 mode", mode, e.md);
          chk(l_drain == e.ld && r_drain == e.rd, "R8 drain flags",
              {l_drain, r_drain}, {e.ld, e.rd});
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    // R1 reset
    repeat (3) step(1, 0, 0, 0, 0);
    idle(2);
    // R5 R10 left-only burst, then R6 R7 drain back to balanced
    step(0, 1, 0, 0, 0);
    idle(4);
    step(0, 0, 1, 0, 0);
    idle(4);
    // R5 right-only burst
    step(0, 0, 0, 1, 0);
    idle(4);
    step(0, 0, 0, 0, 1);
    idle(4);
    // R5 both requesting stays balanced
    step(0, 1, 0, 1, 0);
    idle(3);
    step(0, 0, 1, 0, 1);
    idle(3);
    // R6 burst LR interrupted by right request
    step(0, 1, 0, 0, 0);
    idle(3);
    step(0, 0, 0, 1, 0);
    idle(3);
    step(0, 0, 1, 0, 1);
    idle(4);
    // R7 drain exits directly into opposite burst
    step(0, 1, 0, 0, 0);
    idle(3);
    step(0, 0, 1, 1, 0);
    idle(4);
    step(0, 0, 0, 0, 1);
    idle(4);
    // R7 drain then re-enter same burst
    step(0, 1, 0, 0, 0);
    idle(3);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    idle(4);
    step(0, 0, 1, 0, 0);
    idle(4);
    // R2 simultaneous increment and decrement
    step(0, 1, 0, 0, 0);
    step(0, 1, 1, 1, 1);
    step(0, 0, 1, 0, 0);
    idle(3);
    // R3 underflow attempt
    step(0, 0, 1, 0, 1);
    idle(2);
    // R3 saturation
    for (int i = 0; i < MAXC + 3; i++) step(0, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0);
    for (int i = 0; i < MAXC + 2; i++) step(0, 0, 1, 0, 0);
    idle(4);
    // R1 reset mid-burst
    step(0, 1, 0, 0, 0);
    idle(3);
    step(1, 0, 0, 0, 0);
    idle(3);
    wait (sb.size() == 0);
    @(posedge clk); #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule